// File: doc/BRIEF.md
# Dual-Core Mailbox with Hardware Lock

This block lets two processor cores pass signals to each other through a small register window. Each core owns one mailbox word. While that word holds any nonzero bit, the block raises an interrupt toward the owning core. A sender can overwrite a mailbox word in one write. It can also set or clear chosen bits through two write-only alias registers, so that it never needs a read-modify-write sequence.

A single lock bit gives the two cores a hardware semaphore. One read both tests and takes it: the read returns 1 and marks the lock as taken when it was free, and returns 0 when it was already taken. A write with bit 0 set releases it. The bus is a plain synchronous register port with a word address, separate read and write strobes, and a read data register with one cycle of latency. The window is 256 bytes. The port carries byte-address bits [7:2] only, so byte offsets in this brief are four times the word index.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both mailbox words are zero, both interrupts are low, read data is zero, and the lock is free (the first lock read returns 1).
- R2: A write to the data word of mailbox i (byte offset 16*i + 0x0) replaces all 32 bits. A read of that word returns the contents on `bus_rdata` in the cycle after the read strobe.
- R3: A write to the set alias (16*i + 0x4) ORs the written value into mailbox i. Writing zero leaves the mailbox unchanged.
- R4: A write to the clear alias (16*i + 0x8) clears every mailbox bit written as 1 and keeps the others. Writing zero leaves the mailbox unchanged.
- R5: `irq[i]` is the OR of all bits of mailbox i. It stays high until every bit of that mailbox is cleared. It changes only in the cycle after a write.
- R6: A read of the lock register (byte 0xF8) returns 1 in bit 0 and takes the lock when the lock is free. It returns 0 when the lock is taken. Bits 31:1 always read as 0.
- R7: A write to the lock register with bit 0 = 1 frees the lock. A write with bit 0 = 0 has no effect.
- R8: Reads of the alias words, of the reserved word +0xC, of unimplemented slots 2..14, and of bytes 0xF0, 0xF4 and 0xFC return zero. Such reads change neither a mailbox nor the lock.
- R9: Writes to reserved words, to unimplemented slots and to bytes 0xF0, 0xF4 and 0xFC change neither mailbox and leave both interrupts as they were.
- R10: Only one access is accepted per cycle. When `bus_rd` and `bus_wr` are both high, the write takes effect and the read is dropped: it returns zero and has no side effect on the lock.
- R11: Slot i occupies byte offsets 16*i to 16*i+15. Mailbox 0 belongs to the first core and mailbox 1 to the second core. Accesses to one slot never alter the other mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Word address (byte address bits 7:2) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| irq | output | 2 | Per-core interrupt, index 0 for the first core |

## Verification
The bench builds the block with its default values: two mailboxes, 32-bit words and an 8-bit byte address. With these values both implemented slots can be reached, as can the unimplemented slots 2 to 14 and the top slot, which shares its region with the lock word. Every alias can therefore be checked against a neighbouring mailbox that must not move, and reserved reads can be checked against a lock that must stay free.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    // Word position inside a 16-byte mailbox slot; the bus decoder relies on it.
    typedef enum logic [1:0] {
        WSEL_DATA = 2'd0,
        WSEL_SET  = 2'd1,
        WSEL_CLR  = 2'd2,
        WSEL_RSVD = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic free;
    } lock_state_t;

endpackage

// File: rtl/ipc_mbox_decode.sv
module ipc_mbox_decode
    import ipc_mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BOX   = 2,
    parameter int LOCK_BYTE = 'hF8
) (
    input  logic [ADDR_W-1:2]  waddr,
    input  logic               wr,
    input  logic               rd,
    output logic [NUM_BOX-1:0] box_wr_sel,
    output logic [NUM_BOX-1:0] box_rd_sel,
    output word_sel_e          wsel,
    output logic               lock_wr,
    output logic               lock_rd
);
    localparam int SLOT_BITS = ADDR_W - 4;
    localparam logic [ADDR_W-3:0] LOCK_WORD = (ADDR_W-2)'(LOCK_BYTE >> 2);

    logic [SLOT_BITS-1:0] slot;
    logic                 rd_only;
    logic                 lock_hit;

    always_comb begin
        slot     = waddr[ADDR_W-1:4];
        wsel     = word_sel_e'(waddr[3:2]);
        rd_only  = rd & ~wr;
        lock_hit = (waddr == LOCK_WORD);
        lock_wr  = wr & lock_hit;
        lock_rd  = rd_only & lock_hit;
    end

    for (genvar gi = 0; gi < NUM_BOX; gi++) begin : g_sel
        always_comb begin
            box_wr_sel[gi] = wr & (slot == SLOT_BITS'(gi)) & (wsel != WSEL_RSVD);
            box_rd_sel[gi] = rd_only & (slot == SLOT_BITS'(gi)) & (wsel == WSEL_DATA);
        end
    end

endmodule

// File: rtl/ipc_mbox_cell.sv
module ipc_mbox_cell
    import ipc_mbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  word_sel_e         wsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
    } cell_state_t;

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wsel)
                WSEL_DATA: st_d.word = wdata;
                WSEL_SET:  st_d.word = st_q.word | wdata;
                WSEL_CLR:  st_d.word = st_q.word & ~wdata;
                default:   st_d.word = st_q.word;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.word;
    assign irq  = |st_q.word;

endmodule

// File: rtl/ipc_mbox_lock.sv
module ipc_mbox_lock
    import ipc_mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic wr_en,
    input  logic wbit,
    output logic free
);
    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && wbit) st_d.free = 1'b1;
        else if (take)     st_d.free = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{free: 1'b1};
        else        st_q <= st_d;
    end

    assign free = st_q.free;

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_BOX   = 2,
    parameter int LOCK_BYTE = 'hF8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:2]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_BOX-1:0] irq
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } port_state_t;

    logic [NUM_BOX-1:0]             box_wr_sel;
    logic [NUM_BOX-1:0]             box_rd_sel;
    word_sel_e                      wsel;
    logic                           lock_wr;
    logic                           lock_rd;
    logic                           lock_free;
    logic [NUM_BOX-1:0][DATA_W-1:0] box_word;
    port_state_t                    st_d, st_q;

    ipc_mbox_decode #(
        .ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX), .LOCK_BYTE(LOCK_BYTE)
    ) u_dec (
        .waddr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .box_wr_sel(box_wr_sel), .box_rd_sel(box_rd_sel), .wsel(wsel),
        .lock_wr(lock_wr), .lock_rd(lock_rd)
    );

    for (genvar gb = 0; gb < NUM_BOX; gb++) begin : g_box
        ipc_mbox_cell #(.DATA_W(DATA_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .wr_en(box_wr_sel[gb]), .wsel(wsel),
            .wdata(bus_wdata), .word(box_word[gb]), .irq(irq[gb])
        );
    end

    ipc_mbox_lock u_lock (
        .clk(clk), .rst_n(rst_n), .take(lock_rd & lock_free),
        .wr_en(lock_wr), .wbit(bus_wdata[0]), .free(lock_free)
    );

    always_comb begin
        st_d.rdata = '0;
        for (int i = 0; i < NUM_BOX; i++) begin
            if (box_rd_sel[i]) st_d.rdata = st_d.rdata | box_word[i];
        end
        if (lock_rd) st_d.rdata = DATA_W'(lock_free);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/ipc_mbox_chk.sv
module ipc_mbox_chk #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_BOX   = 2,
    parameter int LOCK_BYTE = 'hF8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:2]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               bus_rd,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_BOX-1:0] irq
);
    localparam int SLOT_BITS = ADDR_W - 4;
    localparam logic [ADDR_W-3:0] LOCK_WORD = (ADDR_W-2)'(LOCK_BYTE >> 2);
    localparam logic [ADDR_W-3:0] B0_DATA   = '0;
    localparam logic [ADDR_W-3:0] B0_SET    = (ADDR_W-2)'(1);
    localparam logic [ADDR_W-3:0] B0_CLR    = (ADDR_W-2)'(2);

    logic rd_only;
    logic lock_read;
    logic quiet_read;
    assign rd_only   = bus_rd & ~bus_wr;
    assign lock_read = rd_only & (bus_addr == LOCK_WORD);
    assign quiet_read = rd_only & (bus_addr[ADDR_W-1:4] != '1) &
                        ((bus_addr[3:2] != 2'b00) ||
                         (bus_addr[ADDR_W-1:4] >= SLOT_BITS'(NUM_BOX)));

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0 && bus_rdata == '0));

    assert_data_replace_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == B0_DATA) |=> (irq[0] == (|$past(bus_wdata))));

    assert_set_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == B0_SET && bus_wdata != '0) |=> irq[0]);

    assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == B0_CLR && (&bus_wdata)) |=> !irq[0]);

    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(irq));

    assert_lock_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_read && $past(lock_read)) |=> (bus_rdata == '0));

    assert_lock_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_read |=> (bus_rdata[DATA_W-1:1] == '0));

    assert_reserved_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_read |=> (bus_rdata == '0));

    assert_one_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr) |=> (bus_rdata == '0));

endmodule

bind ipc_mailbox ipc_mbox_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BOX(NUM_BOX), .LOCK_BYTE(LOCK_BYTE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
);

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
module sim_ipc_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:2]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    int          n_chk = 0;
    int          n_err = 0;

    always #10 clk = ~clk;

    ipc_mailbox u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a[7:2]; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a[7:2]; bus_rd = 1'b1; bus_wr = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 irq", {30'd0, irq}, 32'd0);
        chk("R1 rdata", bus_rdata, 32'd0);
        rd(8'h00, v); chk("R1 box0", v, 32'd0);
        rd(8'h10, v); chk("R1 box1", v, 32'd0);
        rd(8'hF8, v); chk("R1 lock free", v, 32'd1);
        wr(8'hF8, 32'd1);
    endtask

    task automatic t_data_word;
        logic [31:0] v;
        wr(8'h00, 32'hA5A5_0F0F);
        rd(8'h00, v); chk("R2 box0 write", v, 32'hA5A5_0F0F);
        chk("R5 irq after write", {30'd0, irq}, 32'd1);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R2 box1 write", v, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R11 box0 untouched", v, 32'hA5A5_0F0F);
        wr(8'h00, 32'd0);
        rd(8'h00, v); chk("R2 box0 zero", v, 32'd0);
        chk("R5 irq0 low", {30'd0, irq}, 32'd2);
        wr(8'h10, 32'd0);
    endtask

    task automatic t_set_alias;
        logic [31:0] v;
        wr(8'h14, 32'h0000_0011);
        rd(8'h10, v); chk("R3 first set", v, 32'h11);
        wr(8'h14, 32'h0000_0100);
        rd(8'h10, v); chk("R3 OR set", v, 32'h111);
        wr(8'h14, 32'd0);
        rd(8'h10, v); chk("R3 zero set", v, 32'h111);
        chk("R11 irq1 only", {30'd0, irq}, 32'd2);
    endtask

    task automatic t_clear_alias;
        logic [31:0] v;
        wr(8'h18, 32'h0000_0010);
        rd(8'h10, v); chk("R4 partial clear", v, 32'h101);
        wr(8'h18, 32'd0);
        rd(8'h10, v); chk("R4 zero clear", v, 32'h101);
        chk("R5 irq1 held", {30'd0, irq}, 32'd2);
        wr(8'h18, 32'h0000_0101);
        rd(8'h10, v); chk("R4 full clear", v, 32'd0);
        chk("R5 irq1 dropped", {30'd0, irq}, 32'd0);
    endtask

    task automatic t_lock;
        logic [31:0] v;
        rd(8'hF8, v); chk("R6 take", v, 32'd1);
        rd(8'hF8, v); chk("R6 taken", v, 32'd0);
        wr(8'hF8, 32'hFFFF_FFFE);
        rd(8'hF8, v); chk("R7 bit0 zero ignored", v, 32'd0);
        wr(8'hF8, 32'd1);
        rd(8'hF8, v); chk("R7 release", v, 32'd1);
        wr(8'hF8, 32'd1);
    endtask

    task automatic t_reserved;
        logic [31:0] v;
        wr(8'h00, 32'h0000_003C);
        rd(8'h04, v); chk("R8 set alias read", v, 32'd0);
        rd(8'h08, v); chk("R8 clear alias read", v, 32'd0);
        rd(8'h0C, v); chk("R8 reserved word", v, 32'd0);
        rd(8'h20, v); chk("R8 slot2", v, 32'd0);
        rd(8'hE0, v); chk("R8 slot14", v, 32'd0);
        rd(8'hF0, v); chk("R8 byte F0", v, 32'd0);
        rd(8'hF4, v); chk("R8 byte F4", v, 32'd0);
        rd(8'hFC, v); chk("R8 byte FC", v, 32'd0);
        rd(8'h00, v); chk("R8 box0 kept", v, 32'h3C);
        rd(8'hF8, v); chk("R8 lock still free", v, 32'd1);
        wr(8'hF8, 32'd1);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'hF4, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R9 box0 kept", v, 32'h3C);
        rd(8'h10, v); chk("R9 box1 kept", v, 32'd0);
        chk("R9 irq", {30'd0, irq}, 32'd1);
    endtask

    task automatic t_collision;
        logic [31:0] v;
        @(negedge clk);
        bus_addr = 6'h3E; bus_wdata = 32'd0; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R10 lock read dropped", bus_rdata, 32'd0);
        rd(8'hF8, v); chk("R10 lock untouched", v, 32'd1);
        wr(8'hF8, 32'd1);
        @(negedge clk);
        bus_addr = 6'h00; bus_wdata = 32'h77; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R10 data read dropped", bus_rdata, 32'd0);
        rd(8'h00, v); chk("R10 write taken", v, 32'h77);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_data_word;
        t_set_alias;
        t_clear_alias;
        t_lock;
        t_reserved;
        t_collision;
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule